// File: doc/BRIEF.md
# Bidirectional Video Port Buffer

This block is the single word buffer that sits between a video port and the memory-side transfer engine. It holds 16 words of 64 bits, and its direction follows an operating mode. In transmit mode the memory side pushes words in and the port side pops them toward the pins. In capture mode the port side pushes words sampled from the pins and the memory side pops them toward memory. One array serves both directions, so only one writer and one reader are live at any time. The strobes from the other two sides are dropped.

The block keeps two sticky error flags. One records a capture word that arrived while the buffer was full; that word is thrown away. The other records a transmit read that found the buffer empty; the port output then repeats the last word it delivered. Each flag stays set until its write-one-to-clear input is pulsed. The mode is taken from its select input only while the port is disabled. A mode change empties the buffer. The fill and free counts are outputs, so the transfer engine can size its bursts from them.

Top module: `vid_port_fifo`

## Requirements
- R1: After reset, fill_count is 0, free_count is 16, both error flags are 0, the mode is transmit (cap_active = 0) and both read-data outputs are zero.
- R2: In transmit mode (cap_active = 0) with enable high, mem_push stores mem_wdata and port_pop removes the oldest word. The popped word appears on port_rdata in the cycle after the pop and stays there until the next successful pop. mem_rdata reads zero in this mode.
- R3: In capture mode (cap_active = 1) with enable high, port_push stores port_wdata and mem_pop removes the oldest word. The popped word appears on mem_rdata in the cycle after the pop. port_rdata reads zero in this mode.
- R4: fill_count is the number of words held, and free_count is 16 minus fill_count. Both change in the cycle after the push or pop that moves them.
- R5: The strobes of the inactive sides have no effect. In transmit mode these are port_push and mem_pop; in capture mode they are mem_push and port_pop.
- R6: In capture mode, a port_push while fill_count is 16 drops the word and sets err_ovf in the next cycle. The full test uses the count at the start of the cycle, so the push is dropped even if a mem_pop happens in the same cycle.
- R7: In transmit mode, a port_pop while fill_count is 0 sets err_udf in the next cycle. port_rdata then repeats the last word popped, or zero if nothing has been popped since the last mode change or reset.
- R8: Error flags are sticky. A pulse on clr_ovf or clr_udf clears the flag in the next cycle. If a new error and its clear arrive in the same cycle, the flag stays set. A full buffer on a memory-side push, or an empty buffer on a memory-side pop, sets no flag.
- R9: mode_sel is taken only while enable is low. Taking a new mode empties the buffer (fill_count 0) and zeroes the held output word, and leaves the error flags as they are. While enable is high, changes on mode_sel are ignored.
- R10: While enable is low, every push and pop strobe is ignored.
- R11: A push and a pop in the same cycle, on a buffer that is neither full nor empty, both take effect, and fill_count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; mode_sel is taken only while this is low |
| mode_sel | input | 1 | Requested mode: 0 transmit, 1 capture |
| cap_active | output | 1 | Mode in force: 0 transmit, 1 capture |
| mem_push | input | 1 | Memory-side write strobe (used in transmit) |
| mem_wdata | input | 64 | Memory-side write word |
| mem_pop | input | 1 | Memory-side read strobe (used in capture) |
| mem_rdata | output | 64 | Memory-side read word (capture only, else zero) |
| port_push | input | 1 | Port-side write strobe (used in capture) |
| port_wdata | input | 64 | Port-side write word |
| port_pop | input | 1 | Port-side read strobe (used in transmit) |
| port_rdata | output | 64 | Port-side read word (transmit only, else zero) |
| fill_count | output | 5 | Words held |
| free_count | output | 5 | Free entries |
| err_ovf | output | 1 | Sticky capture overflow flag |
| err_udf | output | 1 | Sticky transmit underflow flag |
| clr_ovf | input | 1 | Write-one-to-clear for err_ovf |
| clr_udf | input | 1 | Write-one-to-clear for err_udf |

## Verification
The bench fills the buffer to exactly 16 words in capture mode and then pushes once more. If the design let the pointer wrap, the oldest word would be overwritten and later pops would come out corrupted. It also pushes and pops in the same cycle while the buffer is full. A design that judged fullness after the pop would keep the late word and report no overflow. It pops an empty buffer in transmit mode right after a mode change, where a wrong design would show stale data instead of zero, or would not set the flag. It also moves mode_sel while the port is enabled and pulses the inactive-side strobes in both modes, to catch a design that swaps direction mid-stream or lets a wrong-side strobe move the pointers. A clear that arrives together with a fresh error checks that the set takes priority.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
    typedef enum logic {
        MODE_TX  = 1'b0,
        MODE_CAP = 1'b1
    } vpf_mode_e;
endpackage

// File: rtl/vpf_store.sv
module vpf_store #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/vpf_ctrl.sv
module vpf_ctrl
    import vpf_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_sel,
    input  logic             mem_push,
    input  logic             mem_pop,
    input  logic             port_push,
    input  logic             port_pop,
    input  logic             clr_ovf,
    input  logic             clr_udf,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [WIDTH-1:0] rd_word,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [WIDTH-1:0] wr_data,
    output logic [AW-1:0]    rd_addr,
    output vpf_mode_e        mode,
    output logic [WIDTH-1:0] out_word,
    output logic [CW-1:0]    fill,
    output logic             ovf,
    output logic             udf
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        vpf_mode_e        mode;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CW-1:0]    fill;
        logic             ovf;
        logic             udf;
        logic [WIDTH-1:0] out;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic wr_req, rd_req, is_full, is_empty, do_wr, do_rd;
    logic ovf_evt, udf_evt;

    always_comb begin
        s_d      = s_q;
        is_full  = (s_q.fill == FULL_CNT);
        is_empty = (s_q.fill == '0);
        wr_req   = enable && ((s_q.mode == MODE_TX) ? mem_push : port_push);
        rd_req   = enable && ((s_q.mode == MODE_TX) ? port_pop : mem_pop);
        do_wr    = wr_req && !is_full;
        do_rd    = rd_req && !is_empty;
        ovf_evt  = enable && (s_q.mode == MODE_CAP) && port_push && is_full;
        udf_evt  = enable && (s_q.mode == MODE_TX) && port_pop && is_empty;

        if (do_wr) begin
            s_d.wp = (s_q.wp == LAST_IDX) ? '0 : s_q.wp + AW'(1);
        end
        if (do_rd) begin
            s_d.rp  = (s_q.rp == LAST_IDX) ? '0 : s_q.rp + AW'(1);
            s_d.out = rd_word;
        end
        s_d.fill = s_q.fill + CW'(do_wr) - CW'(do_rd);

        if (clr_ovf) s_d.ovf = 1'b0;
        if (clr_udf) s_d.udf = 1'b0;
        if (ovf_evt) s_d.ovf = 1'b1;
        if (udf_evt) s_d.udf = 1'b1;

        if (!enable && (vpf_mode_e'(mode_sel) != s_q.mode)) begin
            s_d.mode = vpf_mode_e'(mode_sel);
            s_d.wp   = '0;
            s_d.rp   = '0;
            s_d.fill = '0;
            s_d.out  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_TX, wp: '0, rp: '0, fill: '0,
                     ovf: 1'b0, udf: 1'b0, out: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en    = do_wr;
    assign wr_addr  = s_q.wp;
    assign wr_data  = wr_word;
    assign rd_addr  = s_q.rp;
    assign mode     = s_q.mode;
    assign out_word = s_q.out;
    assign fill     = s_q.fill;
    assign ovf      = s_q.ovf;
    assign udf      = s_q.udf;

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_CNT); // R4

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == MODE_CAP && port_push && fill == FULL_CNT) |=> ovf); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == MODE_CAP && port_push && fill == FULL_CNT && !mem_pop)
        |=> (fill == FULL_CNT)); // R6

    AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == MODE_TX && port_pop && fill == '0) |=> (udf && $stable(out_word))); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf); // R8

    AST_NO_OVF_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TX && !ovf) |=> !ovf); // R8

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(mode)); // R9

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $stable(mode)) |=> $stable(fill) || fill == '0); // R10
endmodule

// File: rtl/vid_port_fifo.sv
module vid_port_fifo
    import vpf_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_sel,
    output logic             cap_active,
    input  logic             mem_push,
    input  logic [WIDTH-1:0] mem_wdata,
    input  logic             mem_pop,
    output logic [WIDTH-1:0] mem_rdata,
    input  logic             port_push,
    input  logic [WIDTH-1:0] port_wdata,
    input  logic             port_pop,
    output logic [WIDTH-1:0] port_rdata,
    output logic [CW-1:0]    fill_count,
    output logic [CW-1:0]    free_count,
    output logic             err_ovf,
    output logic             err_udf,
    input  logic             clr_ovf,
    input  logic             clr_udf
);
    logic             wr_en;
    logic [AW-1:0]    wr_addr, rd_addr;
    logic [WIDTH-1:0] wr_data, rd_word, out_word, wr_word;
    vpf_mode_e        mode;
    logic [CW-1:0]    fill;

    assign wr_word = (mode == MODE_TX) ? mem_wdata : port_wdata;

    vpf_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .mode_sel (mode_sel),
        .mem_push (mem_push),
        .mem_pop  (mem_pop),
        .port_push(port_push),
        .port_pop (port_pop),
        .clr_ovf  (clr_ovf),
        .clr_udf  (clr_udf),
        .wr_word  (wr_word),
        .rd_word  (rd_word),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .mode     (mode),
        .out_word (out_word),
        .fill     (fill),
        .ovf      (err_ovf),
        .udf      (err_udf)
    );

    vpf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_word)
    );

    assign cap_active = (mode == MODE_CAP);
    assign port_rdata = (mode == MODE_TX)  ? out_word : '0;
    assign mem_rdata  = (mode == MODE_CAP) ? out_word : '0;
    assign fill_count = fill;
    assign free_count = CW'(DEPTH) - fill;

    AST_FREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count + free_count) == CW'(DEPTH)); // R4

    AST_SIDE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rdata == '0) || (mem_rdata == '0)); // R2
endmodule

// File: tb/vid_port_fifo_bench.sv
module vid_port_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, mode_sel = 1'b0;
    logic        mem_push = 1'b0, mem_pop = 1'b0, port_push = 1'b0, port_pop = 1'b0;
    logic        clr_ovf = 1'b0, clr_udf = 1'b0;
    logic [63:0] mem_wdata = '0, port_wdata = '0;
    logic [63:0] mem_rdata, port_rdata;
    logic [4:0]  fill_count, free_count;
    logic        cap_active, err_ovf, err_udf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vid_port_fifo u_vid_port_fifo (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_sel(mode_sel),
        .cap_active(cap_active), .mem_push(mem_push), .mem_wdata(mem_wdata),
        .mem_pop(mem_pop), .mem_rdata(mem_rdata), .port_push(port_push),
        .port_wdata(port_wdata), .port_pop(port_pop), .port_rdata(port_rdata),
        .fill_count(fill_count), .free_count(free_count), .err_ovf(err_ovf),
        .err_udf(err_udf), .clr_ovf(clr_ovf), .clr_udf(clr_udf)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        mem_push = 0; mem_pop = 0; port_push = 0; port_pop = 0;
        clr_ovf = 0; clr_udf = 0;
    endtask

    task automatic t_reset();
        check("R1 fill", 64'(fill_count), 64'd0);
        check("R1 free", 64'(free_count), 64'd16);
        check("R1 ovf", 64'(err_ovf), 64'd0);
        check("R1 udf", 64'(err_udf), 64'd0);
        check("R1 mode", 64'(cap_active), 64'd0);
        check("R1 port_rdata", port_rdata, 64'd0);
        check("R1 mem_rdata", mem_rdata, 64'd0);
    endtask

    task automatic t_transmit();
        enable = 1;
        for (int i = 0; i < 3; i++) begin
            mem_push = 1; mem_wdata = 64'hA000 + 64'(i);
            step();
        end
        check("R4 fill after 3 pushes", 64'(fill_count), 64'd3);
        check("R4 free after 3 pushes", 64'(free_count), 64'd13);
        mem_pop = 1; port_push = 1; port_wdata = 64'hBAD;
        step();
        check("R5 inactive strobes in transmit", 64'(fill_count), 64'd3);
        check("R5 no ovf from port_push in transmit", 64'(err_ovf), 64'd0);
        mem_push = 1; mem_wdata = 64'hA003; port_pop = 1;
        step();
        check("R11 push+pop keeps fill", 64'(fill_count), 64'd3);
        check("R2 first word out", port_rdata, 64'hA000);
        check("R2 mem_rdata zero in transmit", mem_rdata, 64'd0);
        for (int i = 1; i < 4; i++) begin
            port_pop = 1;
            step();
            check("R2 fifo order", port_rdata, 64'hA000 + 64'(i));
        end
        check("R4 empty after drain", 64'(fill_count), 64'd0);
    endtask

    task automatic t_underflow();
        port_pop = 1;
        step();
        check("R7 udf set", 64'(err_udf), 64'd1);
        check("R7 repeats last word", port_rdata, 64'hA003);
        port_pop = 1; clr_udf = 1;
        step();
        check("R8 set wins over clear", 64'(err_udf), 64'd1);
        step();
        check("R8 sticky", 64'(err_udf), 64'd1);
        clr_udf = 1;
        step();
        check("R8 clear", 64'(err_udf), 64'd0);
    endtask

    task automatic t_mode_lock();
        mode_sel = 1;
        step();
        check("R9 mode held while enabled", 64'(cap_active), 64'd0);
        mem_push = 1; mem_wdata = 64'hE1;
        step();
        check("R9 still transmit path", 64'(fill_count), 64'd1);
        enable = 0;
        mem_push = 1; mem_wdata = 64'hE2; port_pop = 1;
        mode_sel = 0;
        step();
        check("R10 strobes ignored when disabled", 64'(fill_count), 64'd1);
        check("R10 no udf when disabled", 64'(err_udf), 64'd0);
        mode_sel = 1;
        step();
        check("R9 mode taken when disabled", 64'(cap_active), 64'd1);
        check("R9 flush on mode change", 64'(fill_count), 64'd0);
        check("R9 free after flush", 64'(free_count), 64'd16);
    endtask

    task automatic t_capture();
        enable = 1;
        for (int i = 0; i < 16; i++) begin
            port_push = 1; port_wdata = 64'hC000 + 64'(i);
            step();
        end
        check("R4 full fill", 64'(fill_count), 64'd16);
        check("R4 full free", 64'(free_count), 64'd0);
        check("R6 no ovf at exactly full", 64'(err_ovf), 64'd0);
        port_push = 1; port_wdata = 64'hDEAD;
        step();
        check("R6 ovf set", 64'(err_ovf), 64'd1);
        check("R6 word dropped", 64'(fill_count), 64'd16);
        clr_ovf = 1;
        step();
        check("R8 ovf clear", 64'(err_ovf), 64'd0);
        port_push = 1; port_wdata = 64'hBEEF; mem_pop = 1;
        step();
        check("R6 push at full dropped despite pop", 64'(fill_count), 64'd15);
        check("R6 ovf on push+pop at full", 64'(err_ovf), 64'd1);
        check("R3 oldest word out", mem_rdata, 64'hC000);
        check("R3 port_rdata zero in capture", port_rdata, 64'd0);
        port_pop = 1; mem_push = 1; mem_wdata = 64'h77;
        step();
        check("R5 inactive strobes in capture", 64'(fill_count), 64'd15);
        check("R8 no udf in capture", 64'(err_udf), 64'd0);
        for (int i = 1; i < 16; i++) begin
            mem_pop = 1;
            step();
            check("R3 fifo order", mem_rdata, 64'hC000 + 64'(i));
        end
        check("R4 capture drained", 64'(fill_count), 64'd0);
        mem_pop = 1;
        step();
        check("R8 mem pop empty sets no flag", 64'(err_udf), 64'd0);
        check("R8 ovf still sticky", 64'(err_ovf), 64'd1);
    endtask

    task automatic t_udf_zero();
        enable = 0; mode_sel = 0;
        step();
        check("R9 back to transmit", 64'(cap_active), 64'd0);
        check("R9 flags kept across mode change", 64'(err_ovf), 64'd1);
        enable = 1;
        port_pop = 1;
        step();
        check("R7 zero when nothing read", port_rdata, 64'd0);
        check("R7 udf after mode change", 64'(err_udf), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_transmit();
        t_underflow();
        t_mode_lock();
        t_capture();
        t_udf_zero();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule